// File: doc/BRIEF.md
# Tile Table Walker

This block translates 48-bit graphics virtual addresses that fall inside a programmable window reserved for sparse, tiled resources. The window is one sixteenth of the address space, picked by a 4-bit selector that is compared against the top four address bits. A hit starts a walk of a three-level table held in memory. The top two levels hold 64-bit entries that point to the page of the next level. The leaf level holds 32-bit tile numbers with 64 KB granularity. The result is the tile base joined with the 16-bit offset inside the tile. Every address the walker produces is still virtual and goes to a later translation stage.

Requests and responses use valid/ready handshakes, and only one walk is in flight at a time. Table entries are fetched through a plain read port: a one-cycle request pulse, then a data-valid strobe that may come after any latency. Two configurable leaf values flag a null tile, which has no backing memory, and an invalid tile, which faults. When translation is disabled, or the address lies outside the window, the request returns unchanged.

Top module: `sparse_tile_walker`

## Requirements
- R1: A request whose bits [47:44] differ from `cfg_window` returns its own address unchanged, with `rsp_null` and `rsp_fault` low. `rsp_valid` rises in the cycle after acceptance, and no table read is issued.
- R2: With `cfg_enable` low, every request takes the R1 path, including requests whose top bits match `cfg_window`.
- R3: An in-window request issues exactly three reads, in the order top, middle, leaf. The top read address is `{cfg_l3_page, 12'h000}` plus 8 times the index in bits [43:35].
- R4: The middle read address is bits [47:12] of the top entry, shifted left by 12, plus 8 times bits [34:26]. The leaf read address is bits [47:12] of the middle entry, shifted left by 12, plus 4 times bits [25:16]. All other entry bits are ignored.
- R5: `mem_rd_data` is the little-endian 64-bit word at the 8-byte-aligned location that contains the read address. The leaf entry is bits [63:32] when read address bit 2 is set, and bits [31:0] otherwise.
- R6: A normal leaf gives `rsp_addr = {leaf, va[15:0]}`, with both flags low.
- R7: A leaf equal to `cfg_null_val` gives `rsp_null` high, `rsp_addr` zero and `rsp_fault` low. When both marker values are equal, the null outcome wins.
- R8: A leaf equal to `cfg_invalid_val`, and not to `cfg_null_val`, gives `rsp_fault` high, `rsp_null` low and `rsp_addr` equal to the requested address.
- R9: A response holds its address and flags stable until `rsp_ready` takes it.
- R10: After reset `req_ready` is high and `rsp_valid` is low. `req_ready` stays low from acceptance until the response is taken.
- R11: Each table level raises `mem_rd_req` for exactly one cycle. The walk then waits any number of cycles for `mem_rd_dv` before moving to the next level.
- R12: The marker values come only from the configuration inputs. With other markers programmed, a leaf of 0xFFFFFFFF translates as an ordinary tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Tile translation enable for the current context |
| cfg_window | input | 4 | Value of bits [47:44] that selects the reserved window |
| cfg_l3_page | input | 36 | Page number (address >> 12) of the top-level table |
| cfg_null_val | input | 32 | Leaf value that marks a null tile |
| cfg_invalid_val | input | 32 | Leaf value that marks an invalid tile |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_addr | input | 48 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 48 | Translated, passed-through or faulting address |
| rsp_null | output | 1 | Null tile hit |
| rsp_fault | output | 1 | Invalid tile hit |
| mem_rd_req | output | 1 | One-cycle table read request |
| mem_rd_addr | output | 48 | Byte address of the table entry |
| mem_rd_dv | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Aligned 64-bit read data |

## Verification
The assertions check the following on every cycle:
- the one-cycle pass-through timing;
- stability of a stalled response;
- that the request and response sides are never busy at the same time;
- the single-cycle read pulse;
- that a null response carries a zero address;
- that a fault echoes the request;
- that every non-null result keeps the in-tile offset.

Only the bench scenarios can show the rest:
- that the three read addresses are formed from the right index fields and the right entry bits;
- that the correct half of the data word is chosen as the leaf;
- that the window selector decodes correctly across all sixteen values;
- that marker precedence and reprogrammed markers behave as specified.

// File: rtl/stw_pkg.sv
// Shared types for the tile table walker.
// Assumes: nothing beyond the enums below.
package stw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_L3,
        ST_RD_L2,
        ST_RD_L1,
        ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        LVL_TOP,
        LVL_MID,
        LVL_LEAF
    } level_e;

endpackage

// File: rtl/stw_window_decode.sv
// Window decode: flags an address whose top WIN_W bits equal the
// programmed selector while translation is enabled.
// Assumes: the selector is stable while a request is presented.
module stw_window_decode #(
    parameter int WIN_W = 4
) (
    input  logic             enable,
    input  logic [WIN_W-1:0] window,
    input  logic [WIN_W-1:0] va_top,
    output logic             hit
);

    // Compare the top address bits with the selector, gated by enable.
    always_comb begin
        hit = enable && (va_top == window);
    end

endmodule

// File: rtl/stw_entry_addr.sv
// Entry address generator: forms the byte address of the table entry
// for the current level from a page number and the matching index field.
// Assumes: the index field is laid out top | middle | leaf, from MSB to LSB,
// and one table level never spans more than one page.
module stw_entry_addr
    import stw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int L3_IDX_W   = 9,
    parameter int L2_IDX_W   = 9,
    parameter int L1_IDX_W   = 10,
    parameter int UPPER_LOG2 = 3,
    parameter int LEAF_LOG2  = 2
) (
    input  level_e                     level,
    input  logic [VA_W-PAGE_SHIFT-1:0] root_page,
    input  logic [VA_W-PAGE_SHIFT-1:0] prev_page,
    input  logic [L3_IDX_W+L2_IDX_W+L1_IDX_W-1:0] idx_fld,
    output logic [VA_W-1:0]            rd_addr
);

    localparam int IDX_W = L3_IDX_W + L2_IDX_W + L1_IDX_W;

    logic [VA_W-PAGE_SHIFT-1:0] page;
    logic [VA_W-1:0]            byte_off;

    // Choose the page and the scaled index for the level being read.
    always_comb begin
        unique case (level)
            LVL_TOP: begin
                page     = root_page;
                byte_off = VA_W'(idx_fld[IDX_W-1 -: L3_IDX_W]) << UPPER_LOG2;
            end
            LVL_MID: begin
                page     = prev_page;
                byte_off = VA_W'(idx_fld[L1_IDX_W +: L2_IDX_W]) << UPPER_LOG2;
            end
            default: begin
                page     = prev_page;
                byte_off = VA_W'(idx_fld[L1_IDX_W-1:0]) << LEAF_LOG2;
            end
        endcase
    end

    // Join the page base with the entry offset.
    always_comb begin
        rd_addr = {page, {PAGE_SHIFT{1'b0}}} + byte_off;
    end

endmodule

// File: rtl/stw_leaf_decode.sv
// Leaf decoder: picks the leaf entry out of the returned data word,
// classifies it against the null and invalid markers and builds the
// tile address.
// Assumes: DATA_W is a whole multiple of LEAF_W and the word is little-endian.
module stw_leaf_decode #(
    parameter int VA_W       = 48,
    parameter int DATA_W     = 64,
    parameter int LEAF_W     = 32,
    parameter int TILE_SHIFT = 16,
    parameter int LEAVES     = DATA_W / LEAF_W,
    parameter int SEL_W      = (LEAVES > 1) ? $clog2(LEAVES) : 1
) (
    input  logic [DATA_W-1:0]     rd_data,
    input  logic [SEL_W-1:0]      sel,
    input  logic [LEAF_W-1:0]     null_val,
    input  logic [LEAF_W-1:0]     bad_val,
    input  logic [TILE_SHIFT-1:0] offset,
    output logic [VA_W-1:0]       tile_addr,
    output logic                  is_null,
    output logic                  is_bad
);

    logic [LEAF_W-1:0] leaf;

    generate
        if (LEAVES > 1) begin : g_multi
            // Pick the leaf slot named by the low read address bits.
            always_comb begin
                leaf = rd_data[sel*LEAF_W +: LEAF_W];
            end
        end else begin : g_single
            // The word holds a single leaf.
            always_comb begin
                leaf = rd_data[LEAF_W-1:0];
            end
        end
    endgenerate

    // Classify the leaf; null takes precedence over invalid.
    always_comb begin
        is_null   = (leaf == null_val);
        is_bad    = !is_null && (leaf == bad_val);
        tile_addr = (VA_W'(leaf) << TILE_SHIFT) | VA_W'(offset);
    end

endmodule

// File: rtl/sparse_tile_walker.sv
// Tile table walker: translates addresses in the reserved window by
// reading the top, middle and leaf table entries in turn, and passes
// every other address through unchanged. One walk in flight.
// Assumes: configuration inputs are stable while a walk is in progress, and
// the memory answers each one-cycle read pulse with exactly one data-valid.
module sparse_tile_walker
    import stw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int DATA_W     = 64,
    parameter int LEAF_W     = 32,
    parameter int WIN_W      = 4,
    parameter int TILE_SHIFT = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int L3_IDX_W   = 9,
    parameter int L2_IDX_W   = 9,
    parameter int L1_IDX_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_enable,
    input  logic [WIN_W-1:0]           cfg_window,
    input  logic [VA_W-PAGE_SHIFT-1:0] cfg_l3_page,
    input  logic [LEAF_W-1:0]          cfg_null_val,
    input  logic [LEAF_W-1:0]          cfg_invalid_val,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VA_W-1:0]            req_addr,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [VA_W-1:0]            rsp_addr,
    output logic                       rsp_null,
    output logic                       rsp_fault,
    output logic                       mem_rd_req,
    output logic [VA_W-1:0]            mem_rd_addr,
    input  logic                       mem_rd_dv,
    input  logic [DATA_W-1:0]          mem_rd_data
);

    localparam int PG_W       = VA_W - PAGE_SHIFT;
    localparam int IDX_W      = L3_IDX_W + L2_IDX_W + L1_IDX_W;
    localparam int UPPER_LOG2 = $clog2(DATA_W / 8);
    localparam int LEAF_LOG2  = $clog2(LEAF_W / 8);
    localparam int LEAVES     = DATA_W / LEAF_W;
    localparam int SEL_W      = (LEAVES > 1) ? $clog2(LEAVES) : 1;

    walk_state_e      state_q;
    logic             wait_q;
    logic [VA_W-1:0]  va_q;
    logic [PG_W-1:0]  page_q;
    logic [VA_W-1:0]  rsp_addr_q;
    logic             rsp_null_q;
    logic             rsp_fault_q;

    logic             in_win;
    logic             accept;
    logic             rd_done;
    level_e           level;
    logic [VA_W-1:0]  tile_addr;
    logic             leaf_null;
    logic             leaf_bad;

    stw_window_decode #(.WIN_W(WIN_W)) u_win (
        .enable (cfg_enable),
        .window (cfg_window),
        .va_top (req_addr[VA_W-1 -: WIN_W]),
        .hit    (in_win)
    );

    stw_entry_addr #(
        .VA_W       (VA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .L3_IDX_W   (L3_IDX_W),
        .L2_IDX_W   (L2_IDX_W),
        .L1_IDX_W   (L1_IDX_W),
        .UPPER_LOG2 (UPPER_LOG2),
        .LEAF_LOG2  (LEAF_LOG2)
    ) u_addr (
        .level     (level),
        .root_page (cfg_l3_page),
        .prev_page (page_q),
        .idx_fld   (va_q[TILE_SHIFT +: IDX_W]),
        .rd_addr   (mem_rd_addr)
    );

    stw_leaf_decode #(
        .VA_W       (VA_W),
        .DATA_W     (DATA_W),
        .LEAF_W     (LEAF_W),
        .TILE_SHIFT (TILE_SHIFT),
        .LEAVES     (LEAVES),
        .SEL_W      (SEL_W)
    ) u_leaf (
        .rd_data   (mem_rd_data),
        .sel       (mem_rd_addr[LEAF_LOG2 +: SEL_W]),
        .null_val  (cfg_null_val),
        .bad_val   (cfg_invalid_val),
        .offset    (va_q[TILE_SHIFT-1:0]),
        .tile_addr (tile_addr),
        .is_null   (leaf_null),
        .is_bad    (leaf_bad)
    );

    // Handshake and read-port control derived from the walk state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        accept     = req_valid && req_ready;
        mem_rd_req = !wait_q && ((state_q == ST_RD_L3) ||
                                 (state_q == ST_RD_L2) ||
                                 (state_q == ST_RD_L1));
        rd_done    = wait_q && mem_rd_dv;
        rsp_addr   = rsp_addr_q;
        rsp_null   = rsp_null_q;
        rsp_fault  = rsp_fault_q;
    end

    // Map the walk state onto the table level being addressed.
    always_comb begin
        unique case (state_q)
            ST_RD_L3: level = LVL_TOP;
            ST_RD_L2: level = LVL_MID;
            default:  level = LVL_LEAF;
        endcase
    end

    // Walk sequencer: advances one level per returned entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) state_q <= in_win ? ST_RD_L3 : ST_RESP;
                end
                ST_RD_L3, ST_RD_L2, ST_RD_L1: begin
                    if (mem_rd_req) begin
                        wait_q <= 1'b1;
                    end else if (rd_done) begin
                        wait_q  <= 1'b0;
                        state_q <= (state_q == ST_RD_L3) ? ST_RD_L2 :
                                   (state_q == ST_RD_L2) ? ST_RD_L1 : ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request address and the page pointer of each upper entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            page_q <= '0;
        end else begin
            if (accept) va_q <= req_addr;
            if (rd_done && (state_q != ST_RD_L1))
                page_q <= mem_rd_data[VA_W-1:PAGE_SHIFT];
        end
    end

    // Response register: loaded on bypass or when the leaf returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr_q  <= '0;
            rsp_null_q  <= 1'b0;
            rsp_fault_q <= 1'b0;
        end else if (accept && !in_win) begin
            rsp_addr_q  <= req_addr;
            rsp_null_q  <= 1'b0;
            rsp_fault_q <= 1'b0;
        end else if (rd_done && (state_q == ST_RD_L1)) begin
            rsp_null_q  <= leaf_null;
            rsp_fault_q <= leaf_bad;
            if (leaf_null)     rsp_addr_q <= '0;
            else if (leaf_bad) rsp_addr_q <= va_q;
            else               rsp_addr_q <= tile_addr;
        end
    end

    // Pass-through answers in the next cycle with the untouched address.
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_win) |=> (rsp_valid && rsp_addr == $past(req_addr)
                                 && !rsp_null && !rsp_fault));

    // Non-null results keep the in-tile offset of the request.
    assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_null) |-> (rsp_addr[TILE_SHIFT-1:0] == va_q[TILE_SHIFT-1:0]));

    // A null response carries no address and no fault.
    assert_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_null) |-> (rsp_addr == '0 && !rsp_fault));

    // A fault echoes the requested address.
    assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == va_q));

    // A stalled response does not change.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                       && $stable(rsp_null) && $stable(rsp_fault)));

    // While a response is pending no request is taken and no read goes out.
    assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !mem_rd_req));

    // Every read request lasts exactly one cycle.
    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

endmodule

// File: tb/sim_sparse_tile_walker.sv
module sim_sparse_tile_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [3:0]  cfg_window = 4'hF;
    logic [35:0] cfg_l3_page = 36'h1;
    logic [31:0] cfg_null_val = 32'hFFFF_FFFF;
    logic [31:0] cfg_invalid_val = 32'hFFFF_FFFE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [47:0] rsp_addr;
    logic        rsp_null;
    logic        rsp_fault;
    logic        mem_rd_req;
    logic [47:0] mem_rd_addr;
    logic        mem_rd_dv = 1'b0;
    logic [63:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [47:0] L3PG = 48'h1000;
    localparam logic [47:0] L2PG = 48'h2000;
    localparam logic [47:0] L1PG = 48'h3000;
    localparam logic [63:0] L3ENT = 64'hA5A5_0000_0000_27C1;
    localparam logic [63:0] L2ENT = 64'hFFFF_0000_0000_3FFF;

    always #2 clk = ~clk;

    sparse_tile_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_window(cfg_window),
        .cfg_l3_page(cfg_l3_page), .cfg_null_val(cfg_null_val),
        .cfg_invalid_val(cfg_invalid_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_null(rsp_null), .rsp_fault(rsp_fault),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_dv(mem_rd_dv), .mem_rd_data(mem_rd_data)
    );

    // Table memory model with a programmable read latency and a read log.
    logic [63:0] mem [0:4095];
    logic [47:0] rd_log [0:63];
    int          rd_n = 0;
    int          mem_lat = 0;
    int          lat_cnt = 0;
    logic        busy = 1'b0;
    logic [47:0] pend_addr = '0;

    always @(posedge clk) begin
        mem_rd_dv <= 1'b0;
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (mem_rd_req) begin
            busy      <= 1'b1;
            lat_cnt   <= mem_lat;
            pend_addr <= mem_rd_addr;
            rd_log[rd_n % 64] <= mem_rd_addr;
            rd_n <= rd_n + 1;
        end else if (busy) begin
            if (lat_cnt == 0) begin
                mem_rd_dv   <= 1'b1;
                mem_rd_data <= mem[(pend_addr >> 3) & 48'hFFF];
                busy        <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [47:0] mkva(input logic [3:0] w, input int i3, input int i2,
                                         input int i1, input int off);
        return {w, 9'(i3), 9'(i2), 10'(i1), 16'(off)};
    endfunction

    // Program one path through the tables; the leaf goes to the half
    // selected by bit 2 of its byte address (R5).
    task automatic prog(input int i3, input int i2, input int i1, input logic [31:0] leaf);
        logic [47:0] a;
        a = L3PG + 48'(i3 * 8);
        mem[(a >> 3) & 48'hFFF] = L3ENT;
        a = L2PG + 48'(i2 * 8);
        mem[(a >> 3) & 48'hFFF] = L2ENT;
        a = L1PG + 48'(i1 * 4);
        if (a[2]) mem[(a >> 3) & 48'hFFF][63:32] = leaf;
        else      mem[(a >> 3) & 48'hFFF][31:0]  = leaf;
    endtask

    task automatic run_req(input logic [47:0] va, input int lat, input logic [47:0] exp_a,
                           input logic exp_n, input logic exp_f, input int exp_rd,
                           input string tag);
        int base;
        int waited;
        logic [47:0] held;
        @(negedge clk);
        mem_lat   = lat;
        base      = rd_n;
        req_valid = 1'b1;
        req_addr  = va;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        if (exp_rd == 0) check({tag, " R1 next-cycle response"}, 64'(rsp_valid), 64'd1);
        else             check({tag, " R10 busy after accept"}, 64'(req_ready), 64'd0);
        waited = 0;
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " R6 address"}, 64'(rsp_addr), 64'(exp_a));
        check({tag, " R7 null flag"}, 64'(rsp_null), 64'(exp_n));
        check({tag, " R8 fault flag"}, 64'(rsp_fault), 64'(exp_f));
        check({tag, " R11 read count"}, 64'(rd_n - base), 64'(exp_rd));
        if (exp_rd == 3) begin
            check({tag, " R3 top read"}, 64'(rd_log[base % 64]),
                  64'(L3PG + 48'(va[43:35]) * 8));
            check({tag, " R4 middle read"}, 64'(rd_log[(base + 1) % 64]),
                  64'(L2PG + 48'(va[34:26]) * 8));
            check({tag, " R4 leaf read"}, 64'(rd_log[(base + 2) % 64]),
                  64'(L1PG + 48'(va[25:16]) * 4));
        end
        held = rsp_addr;
        @(negedge clk);
        check({tag, " R9 held valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " R9 held address"}, 64'(rsp_addr), 64'(held));
        check({tag, " R10 no accept while pending"}, 64'(req_ready), 64'd0);
        rsp_ready = 1'b1;
        @(posedge clk);
        #1 rsp_ready = 1'b0;
        @(negedge clk);
        check({tag, " R10 idle again"}, 64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        cfg_l3_page = L3PG[47:12];
        repeat (3) @(negedge clk);
        check("R10 reset ready", 64'(req_ready), 64'd1);
        check("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 reset no read", 64'(mem_rd_req), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Window sweep over all sixteen selectors (R1, R3).
        prog(0, 0, 0, 32'h0000_0001);
        for (int w = 0; w < 16; w++) begin
            logic [47:0] va;
            cfg_window = 4'(w);
            va = mkva(4'h9, 0, 0, 0, 16'h0042);
            if (w == 9) run_req(va, w % 4, {32'h1, 16'h0042}, 1'b0, 1'b0, 3, "R3 window hit");
            else        run_req(va, 0, va, 1'b0, 1'b0, 0, "R1 window miss");
        end

        // Disabled translation bypasses even a matching window (R2).
        cfg_enable = 1'b0;
        run_req(mkva(4'h9, 0, 0, 0, 16'h0042), 0, mkva(4'h9, 0, 0, 0, 16'h0042),
                1'b0, 1'b0, 0, "R2 disabled");
        cfg_enable = 1'b1;
        cfg_window = 4'hF;

        // Walks over assorted index fields, offsets and latencies (R3..R6, R11).
        for (int k = 0; k < 6; k++) begin
            int i3; int i2; int i1; int off;
            logic [31:0] leaf;
            logic [47:0] va;
            case (k)
                0: begin i3 = 0;   i2 = 0;   i1 = 0;    off = 16'h0000; leaf = 32'h0000_0001; end
                1: begin i3 = 511; i2 = 511; i1 = 1023; off = 16'hFFFC; leaf = 32'h0000_FFFF; end
                2: begin i3 = 1;   i2 = 2;   i1 = 3;    off = 16'h1234; leaf = 32'h00AB_CDEF; end
                3: begin i3 = 256; i2 = 100; i1 = 512;  off = 16'h8000; leaf = 32'h7FFF_FFFF; end
                4: begin i3 = 37;  i2 = 400; i1 = 1;    off = 16'h0001; leaf = 32'hFFFF_FFFD; end
                default: begin i3 = 5; i2 = 5; i1 = 6;  off = 16'hABCD; leaf = 32'h1357_9BDF; end
            endcase
            prog(i3, i2, i1, leaf);
            va = mkva(4'hF, i3, i2, i1, off);
            run_req(va, k % 4, {leaf, 16'(off)}, 1'b0, 1'b0, 3, "R5 walk");
        end

        // Default markers: null and invalid tiles (R7, R8).
        prog(3, 4, 7, 32'hFFFF_FFFF);
        run_req(mkva(4'hF, 3, 4, 7, 16'h0100), 1, 48'h0, 1'b1, 1'b0, 3, "R7 null tile");
        prog(3, 4, 8, 32'hFFFF_FFFE);
        run_req(mkva(4'hF, 3, 4, 8, 16'h0200), 2, mkva(4'hF, 3, 4, 8, 16'h0200),
                1'b0, 1'b1, 3, "R8 invalid tile");

        // Reprogrammed markers (R12).
        cfg_null_val    = 32'h0000_00AA;
        cfg_invalid_val = 32'h0000_00BB;
        prog(3, 4, 7, 32'hFFFF_FFFF);
        run_req(mkva(4'hF, 3, 4, 7, 16'h0300), 0, {32'hFFFF_FFFF, 16'h0300},
                1'b0, 1'b0, 3, "R12 old marker translates");
        prog(9, 9, 9, 32'h0000_00AA);
        run_req(mkva(4'hF, 9, 9, 9, 16'h0400), 3, 48'h0, 1'b1, 1'b0, 3, "R12 new null");
        prog(9, 9, 10, 32'h0000_00BB);
        run_req(mkva(4'hF, 9, 9, 10, 16'h0500), 0, mkva(4'hF, 9, 9, 10, 16'h0500),
                1'b0, 1'b1, 3, "R12 new invalid");

        // Equal markers: null wins (R7).
        cfg_null_val    = 32'h0000_00CC;
        cfg_invalid_val = 32'h0000_00CC;
        prog(2, 2, 2, 32'h0000_00CC);
        run_req(mkva(4'hF, 2, 2, 2, 16'h0600), 1, 48'h0, 1'b1, 1'b0, 3, "R7 null precedence");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule